// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block is a multi-channel interval timer for a register-mapped host. Every channel owns an up-counter, a compare register and a control/status register. A single start register is shared by all channels and holds one run bit per channel. A running channel advances its counter on a tick from its own prescaler. When the count equals the compare value, the next tick returns the counter to zero and sets a sticky match flag. If the interrupt enable is set, the flag drives the channel's interrupt line.

A host write to a counter does not take effect at once. It is held in a small per-channel synchronizer state machine. The write is applied on the second prescaler tick after it arrives, so that the deferred update of a slow timer clock is reproduced. The synchronizer has three states: SYN_IDLE, SYN_ARMED and SYN_HALF. A write moves it from any state to SYN_ARMED. A tick moves it from SYN_ARMED to SYN_HALF. A tick in SYN_HALF moves it back to SYN_IDLE and loads the counter. A new write in any state restarts the sequence and replaces the pending value.

Top module: `cmt_timer`

## Requirements
- R1: After reset every counter reads 0, every compare register reads all ones, every control register reads 0, the start register reads 0 and all interrupt lines are low.
- R2: Word index 0 is the start register, and bit c of it belongs to channel c. Channel c sits at word index 4*(c+1): offset 0 is control, offset 1 is the counter and offset 2 is the compare register. Control bits [1:0] are the clock select, bit 6 is the interrupt enable and bit 7 is the match flag.
- R3: Clock select values 0, 1, 2 and 3 make the counter tick once every 8, 32, 128 and 512 clock cycles.
- R4: While a channel's start bit is set, a tick with count equal to compare returns the count to 0 and sets the flag. A full period is therefore (compare+1) times the divide ratio, in clock cycles.
- R5: While its start bit is clear, a channel's counter holds. Starting one channel does not move another channel's counter.
- R6: The match flag is sticky. Writing control with bit 7 at 0 clears it, and writing bit 7 at 1 leaves it as it is. Both kinds of write update the clock select and enable fields.
- R7: The interrupt line of a channel is high exactly while its match flag and its interrupt enable are both set.
- R8: A counter write is applied on the second tick after the write. Until then, reads return the old count. A later write restarts the wait and its value wins.
- R9: A compare write takes effect at once. If the count is already above the new value, the counter runs to all ones and wraps to 0 without setting the flag. The flag is set at the next true match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; rdata is zero when low |
| addr | input | ADDR_W | Word index |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data, combinational from addr |
| irq | output | NUM_CH | Per-channel interrupt level |

## Verification
Period length is measured between consecutive interrupt rises under a table of compare/clock-select pairs. A compare of 0 checks that every tick matches, and each divide ratio is checked in turn, so an off-by-one in the wrap or a wrong divider gives a distinct cycle count. Directed sequences then cover the following:
- flag write-one versus write-zero;
- an enable-masked flag;
- a run of one channel while its neighbour is stopped;
- reads taken before and after the counter-write delay, and a superseding write;
- a compare lowered below the current count, which must wrap through all ones without a flag.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
    typedef enum logic [1:0] {
        SYN_IDLE  = 2'd0,
        SYN_ARMED = 2'd1,
        SYN_HALF  = 2'd2
    } sync_state_e;

    localparam int CKS_W     = 2;
    localparam int IE_BIT    = 6;
    localparam int FLAG_BIT  = 7;
    localparam int BASE_LOG  = 3;   // divide by 8 at select 0
    localparam int STEP_LOG  = 2;   // x4 per select step
    localparam int PRE_W     = BASE_LOG + STEP_LOG * ((1 << CKS_W) - 1);
    localparam int OFS_CTRL  = 0;
    localparam int OFS_CNT   = 1;
    localparam int OFS_CMP   = 2;
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
    import cmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CKS_W-1:0] cks,
    output logic             tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    always_comb begin
        for (int i = 0; i < PRE_W; i++)
            mask[i] = (i < (BASE_LOG + STEP_LOG * int'(cks)));
    end

    assign tick = ((pre_q & mask) == mask);

    // R3: smallest ratio is 8, so ticks never come back to back
    p_tick_spaced_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/cmt_write_sync.sv
module cmt_write_sync
    import cmt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic         apply,
    output logic [W-1:0] load_val
);
    sync_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= SYN_IDLE;
            load_val <= '0;
        end else begin
            st_q <= st_d;
            if (wr) load_val <= wdata;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SYN_IDLE:  st_d = SYN_IDLE;
            SYN_ARMED: if (tick) st_d = SYN_HALF;
            SYN_HALF:  if (tick) st_d = SYN_IDLE;
            default:   st_d = SYN_IDLE;
        endcase
        if (wr) st_d = SYN_ARMED;
    end

    always_comb begin
        apply = (st_q == SYN_HALF) && tick && !wr;
    end

    // R8: a write is never applied on the very next edge
    p_no_instant_apply_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !apply);
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
    import cmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ctrl_we,
    input  logic             cnt_we,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] ctrl_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cmp_q,
    output logic             irq
);
    logic [CKS_W-1:0] cks_q;
    logic             ie_q;
    logic             flag_q;
    logic             tick;
    logic             apply;
    logic [CNT_W-1:0] load_val;
    logic             match;

    cmt_prescaler u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .cks  (cks_q),
        .tick (tick)
    );

    cmt_write_sync #(.W(CNT_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr      (cnt_we),
        .wdata   (wdata),
        .apply   (apply),
        .load_val(load_val)
    );

    assign match = run && tick && !apply && (cnt_q == cmp_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            cmp_q  <= '1;
            cks_q  <= '0;
            ie_q   <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (apply)             cnt_q <= load_val;
            else if (run && tick)  cnt_q <= match ? '0 : cnt_q + 1'b1;
            if (cmp_we) cmp_q <= wdata;
            if (ctrl_we) begin
                cks_q <= wdata[CKS_W-1:0];
                ie_q  <= wdata[IE_BIT];
            end
            if (match)                            flag_q <= 1'b1;
            else if (ctrl_we && !wdata[FLAG_BIT]) flag_q <= 1'b0;
        end
    end

    always_comb begin
        ctrl_q            = '0;
        ctrl_q[CKS_W-1:0] = cks_q;
        ctrl_q[IE_BIT]    = ie_q;
        ctrl_q[FLAG_BIT]  = flag_q;
    end

    assign irq = flag_q & ie_q;

    p_match_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> (cnt_q == '0) && ctrl_q[FLAG_BIT]);

    p_hold_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !apply) |=> $stable(cnt_q));

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(ctrl_we && !wdata[FLAG_BIT])) |=> flag_q);

    p_wrap_no_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !apply && (cnt_q == '1) && (cmp_q != '1) && !flag_q)
        |=> (cnt_q == '0) && !flag_q);
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
    import cmt_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic [NUM_CH-1:0] irq
);
    localparam int SEL_W = ADDR_W - 2;

    logic [NUM_CH-1:0] start_q;
    logic [CNT_W-1:0]  ctrl_a [NUM_CH];
    logic [CNT_W-1:0]  cnt_a  [NUM_CH];
    logic [CNT_W-1:0]  cmp_a  [NUM_CH];
    logic              start_hit;

    assign start_hit = (addr == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  start_q <= '0;
        else if (wr_en && start_hit) start_q <= wdata[NUM_CH-1:0];
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel;
        assign sel = (addr[ADDR_W-1:2] == SEL_W'(c + 1));

        cmt_channel #(.CNT_W(CNT_W)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (start_q[c]),
            .ctrl_we(wr_en && sel && (addr[1:0] == 2'(OFS_CTRL))),
            .cnt_we (wr_en && sel && (addr[1:0] == 2'(OFS_CNT))),
            .cmp_we (wr_en && sel && (addr[1:0] == 2'(OFS_CMP))),
            .wdata  (wdata),
            .ctrl_q (ctrl_a[c]),
            .cnt_q  (cnt_a[c]),
            .cmp_q  (cmp_a[c]),
            .irq    (irq[c])
        );
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (start_hit) rdata = CNT_W'(start_q);
            for (int c = 0; c < NUM_CH; c++) begin
                if (addr[ADDR_W-1:2] == SEL_W'(c + 1)) begin
                    unique case (addr[1:0])
                        2'(OFS_CTRL): rdata = ctrl_a[c];
                        2'(OFS_CNT):  rdata = cnt_a[c];
                        2'(OFS_CMP):  rdata = cmp_a[c];
                        default:      rdata = '0;
                    endcase
                end
            end
        end
    end

    // R1: nothing runs straight out of reset
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (start_q == '0));
endmodule

// File: tb/tb_cmt_timer.sv
module tb_cmt_timer;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH = 2;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 4;

    localparam logic [3:0] A_START = 4'd0;
    localparam logic [3:0] A_CTRL0 = 4'd4;
    localparam logic [3:0] A_CNT0  = 4'd5;
    localparam logic [3:0] A_CMP0  = 4'd6;
    localparam logic [3:0] A_CTRL1 = 4'd8;
    localparam logic [3:0] A_CNT1  = 4'd9;
    localparam logic [3:0] A_CMP1  = 4'd10;
    localparam logic [15:0] IE   = 16'h0040;
    localparam logic [15:0] FLAG = 16'h0080;

    // {compare, clock select, expected period in cycles}
    localparam int NVEC = 4;
    localparam int VEC [NVEC][3] = '{
        '{3, 0, 32},
        '{0, 0, 8},
        '{5, 1, 192},
        '{1, 3, 1024}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [CNT_W-1:0]  wdata = '0;
    logic [CNT_W-1:0]  rdata;
    logic [NUM_CH-1:0] irq;

    int checks = 0;
    int failures = 0;

    cmt_timer #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq0(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            if (irq[0]) begin seen = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] v, v2;
        bit seen;
        longint t0, t1;

        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1 reset state, R2 map
        rd(A_CTRL0, v); check(v == 16'h0, "R1 ctrl0 reset", v, 0);
        rd(A_CNT0, v);  check(v == 16'h0, "R1 cnt0 reset", v, 0);
        rd(A_CMP0, v);  check(v == 16'hFFFF, "R1 cmp0 reset", v, 16'hFFFF);
        rd(A_CMP1, v);  check(v == 16'hFFFF, "R1 cmp1 reset", v, 16'hFFFF);
        rd(A_START, v); check(v == 16'h0, "R1 start reset", v, 0);
        check(irq == '0, "R1 irq reset", irq, 0);
        wr(A_CMP1, 16'h1234);
        rd(A_CMP1, v); check(v == 16'h1234, "R2 cmp1 map", v, 16'h1234);
        rd(A_CMP0, v); check(v == 16'hFFFF, "R2 cmp0 untouched", v, 16'hFFFF);

        // R3 R4 R7: period table
        for (int k = 0; k < NVEC; k++) begin
            wr(A_START, 16'h0);
            wr(A_CMP0, 16'(VEC[k][0]));
            wr(A_CTRL0, 16'(VEC[k][1]) | IE);
            wr(A_CNT0, 16'h0);
            wait_cyc(1100);
            wr(A_START, 16'h1);
            wait_irq0(seen);
            t0 = $time;
            wr(A_CTRL0, 16'(VEC[k][1]) | IE);
            wait_irq0(seen);
            t1 = $time;
            check(seen && ((t1 - t0) / CLK_PERIOD == longint'(VEC[k][2])),
                  "R3 R4 R7 period", int'((t1 - t0) / CLK_PERIOD), VEC[k][2]);
            wr(A_START, 16'h0);
            wr(A_CTRL0, 16'(VEC[k][1]));
        end

        // R6 R7: flag semantics
        wr(A_CTRL0, 16'h0000);
        wr(A_CMP0, 16'd2);
        wr(A_CNT0, 16'h0);
        wait_cyc(40);
        wr(A_START, 16'h1);
        wait_cyc(100);
        wr(A_START, 16'h0);
        rd(A_CTRL0, v); check(v == FLAG, "R6 flag set", v, FLAG);
        check(irq[0] == 1'b0, "R7 masked irq", irq[0], 0);
        wr(A_CTRL0, FLAG | IE);
        rd(A_CTRL0, v); check(v == (FLAG | IE), "R6 write one keeps", v, FLAG | IE);
        check(irq[0] == 1'b1, "R7 irq level", irq[0], 1);
        wr(A_CTRL0, IE | 16'h1);
        rd(A_CTRL0, v); check(v == (IE | 16'h1), "R6 write zero clears", v, IE | 16'h1);
        check(irq[0] == 1'b0, "R7 irq drops", irq[0], 0);
        wr(A_CTRL0, 16'h0);

        // R8 with R5: ch1 counter load, then isolation
        wr(A_CNT1, 16'd7);
        wait_cyc(40);
        rd(A_CNT1, v); check(v == 16'd7, "R8 load visible", v, 7);
        wr(A_CMP0, 16'hFFFF);
        wr(A_START, 16'h1);
        wait_cyc(300);
        rd(A_CNT1, v); check(v == 16'd7, "R5 other channel holds", v, 7);
        rd(A_CNT0, v);
        wait_cyc(50);
        rd(A_CNT0, v2); check(v2 > v, "R5 running channel moves", v2, v + 1);
        wr(A_START, 16'h0);
        rd(A_CNT0, v);
        wait_cyc(200);
        rd(A_CNT0, v2); check(v2 == v, "R5 stopped channel holds", v2, v);

        // R8 deferred counter write
        wr(A_CNT1, 16'd100);
        rd(A_CNT1, v); check(v == 16'd7, "R8 old value before delay", v, 7);
        wait_cyc(20);
        rd(A_CNT1, v); check(v == 16'd100, "R8 new value after delay", v, 100);
        wr(A_CNT1, 16'd200);
        wait_cyc(3);
        wr(A_CNT1, 16'd300);
        wait_cyc(20);
        rd(A_CNT1, v); check(v == 16'd300, "R8 later write wins", v, 300);

        // R9 compare below count: wrap without flag
        wr(A_CTRL0, 16'h0);
        wr(A_CNT0, 16'd65530);
        wait_cyc(30);
        wr(A_CMP0, 16'd3);
        wr(A_START, 16'h1);
        seen = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            rd(A_CNT0, v);
            if (v == 16'd1) begin seen = 1'b1; break; end
        end
        rd(A_CTRL0, v2);
        check(seen && v2 == 16'h0, "R9 wrap sets no flag", v2, 0);
        wait_cyc(40);
        rd(A_CTRL0, v2);
        check(v2 == FLAG, "R9 flag at next match", v2, FLAG);
        wr(A_START, 16'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule